// File: doc/BRIEF.md
# VGA Raster Sync Generator

This block turns a pixel-rate enable into the timing a VGA monitor needs for 640x480 progressive scan at 60 Hz. It produces a horizontal pixel count, a vertical line count, horizontal and vertical sync pulses, and a flag that is high while the scan is inside the visible picture. It runs from any system clock. A one-cycle `pix_en` strobe at the pixel rate advances the scan by one pixel. For example, a 100 MHz clock with an enable on every fourth cycle gives the 25 MHz pixel rate.

The counts start at the first visible pixel. Pixels 0 to 639 and lines 0 to 479 are the picture, so downstream logic can use the counts directly as coordinates. Each line is made of the visible pixels, then the front porch, the sync pulse and the back porch. Frames are built from lines in the same way.

The output stage takes an 8-bit colour word laid out as red, green and blue with 3, 3 and 2 bits. It passes the word through while the scan is visible and forces it to zero at all other times. Porch lengths, sync widths and sync polarities are parameters, so the same block can drive other modes.

Top module: `vga_scan_timer`

## Requirements
- R1: While `rst_n` is low, `hpos` and `vpos` are 0. The first position after reset is therefore the top-left visible pixel.
- R2: On a clock edge where `pix_en` is low, `hpos` and `vpos` keep their values.
- R3: On each clock edge with `pix_en` high, `hpos` increments by one. It wraps from H_TOTAL-1 to 0, where H_TOTAL is 800 by default.
- R4: `vpos` changes only on an edge where `hpos` wraps. On that edge it increments by one, and it wraps from V_TOTAL-1 to 0, where V_TOTAL is 525 by default.
- R5: `hsync` is at its active level exactly while `hpos` is in [H_VIS+H_FP, H_VIS+H_FP+H_SYNC). By default this is 656 to 751, and the active level is low.
- R6: `vsync` is at its active level exactly while `vpos` is in [V_VIS+V_FP, V_VIS+V_FP+V_SYNC). By default this is 490 to 491, and the active level is low. `hsync` keeps pulsing while `vsync` is active.
- R7: `video_on` is high exactly when `hpos` < H_VIS and `vpos` < V_VIS. By default these limits are 640 and 480.
- R8: While `video_on` is high, `red` = `pix_rgb[7:5]`, `green` = `pix_rgb[4:2]` and `blue` = `pix_rgb[1:0]`. Otherwise all three colour outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_en | input | 1 | Advances the scan by one pixel |
| pix_rgb | input | 8 | Colour in, red 7:5, green 4:2, blue 1:0 |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| hpos | output | CW | Pixel count within the line |
| vpos | output | CW | Line count within the frame |
| video_on | output | 1 | High inside the visible picture |
| red | output | 3 | Blanked red |
| green | output | 3 | Blanked green |
| blue | output | 2 | Blanked blue |

## Verification
The vertical sync window and the wrap at the end of a frame are hard to reach at the default size. At 800 pixels per line, vsync starts only after 392,000 pixel enables, which is too many for a short run. The bench therefore runs a second instance with a tiny mode: 32 pixels per line, 20 lines per frame and an active-high horizontal sync. With irregular enables, that instance passes through several complete frames, through the vsync window and through a mid-frame reset. The default-size instance runs long enough to cover its own horizontal sync window and the line wrap at 799.

// File: rtl/vga_scan_timer.sv
module vga_scan_timer #(
  parameter int H_VIS   = 640,
  parameter int H_FP    = 16,
  parameter int H_SYNC  = 96,
  parameter int H_BP    = 48,
  parameter int V_VIS   = 480,
  parameter int V_FP    = 10,
  parameter int V_SYNC  = 2,
  parameter int V_BP    = 33,
  parameter bit HS_HIGH = 1'b0,
  parameter bit VS_HIGH = 1'b0,
  parameter int CW      = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic [7:0]    pix_rgb,
  output logic          hsync,
  output logic          vsync,
  output logic [CW-1:0] hpos,
  output logic [CW-1:0] vpos,
  output logic          video_on,
  output logic [2:0]    red,
  output logic [2:0]    green,
  output logic [1:0]    blue
);

  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;

  localparam logic [CW-1:0] H_LAST   = CW'(H_TOTAL - 1);
  localparam logic [CW-1:0] V_LAST   = CW'(V_TOTAL - 1);
  localparam logic [CW-1:0] H_VIS_C  = CW'(H_VIS);
  localparam logic [CW-1:0] V_VIS_C  = CW'(V_VIS);
  localparam logic [CW-1:0] HS_BEG   = CW'(H_VIS + H_FP);
  localparam logic [CW-1:0] HS_END   = CW'(H_VIS + H_FP + H_SYNC);
  localparam logic [CW-1:0] VS_BEG   = CW'(V_VIS + V_FP);
  localparam logic [CW-1:0] VS_END   = CW'(V_VIS + V_FP + V_SYNC);

  logic line_end;
  logic frame_end;
  logic hs_on;
  logic vs_on;

  assign line_end  = (hpos == H_LAST);
  assign frame_end = (vpos == V_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hpos <= '0;
      vpos <= '0;
    end else if (pix_en) begin
      hpos <= line_end ? '0 : hpos + 1'b1;
      if (line_end)
        vpos <= frame_end ? '0 : vpos + 1'b1;
    end
  end

  assign hs_on    = (hpos >= HS_BEG) && (hpos < HS_END);
  assign vs_on    = (vpos >= VS_BEG) && (vpos < VS_END);
  assign hsync    = hs_on ? HS_HIGH : ~HS_HIGH;
  assign vsync    = vs_on ? VS_HIGH : ~VS_HIGH;
  assign video_on = (hpos < H_VIS_C) && (vpos < V_VIS_C);

  assign red   = video_on ? pix_rgb[7:5] : 3'd0;
  assign green = video_on ? pix_rgb[4:2] : 3'd0;
  assign blue  = video_on ? pix_rgb[1:0] : 2'd0;

  AST_RESET_ORIGIN: assert property (@(posedge clk)
    !rst_n |=> (hpos == '0) && (vpos == '0)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(hpos) && $stable(vpos)); // R2

  AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && hpos == H_LAST) |=> (hpos == '0)); // R3

  AST_H_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hpos <= H_LAST); // R3

  AST_V_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (hpos != H_LAST) |=> $stable(vpos)); // R4

  AST_V_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && hpos == H_LAST && vpos == V_LAST) |=> (vpos == '0)); // R4

  AST_BLANK_RGB: assert property (@(posedge clk) disable iff (!rst_n)
    !video_on |-> (red == 3'd0) && (green == 3'd0) && (blue == 2'd0)); // R8

  AST_NO_VIDEO_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync == HS_HIGH) |-> !video_on); // R7

endmodule

// File: tb/vga_scan_timer_bench.sv
module vga_scan_timer_bench;
  localparam int CLK_PERIOD = 10;

  localparam int SH_VIS = 20, SH_FP = 3, SH_SYNC = 5, SH_BP = 4;
  localparam int SV_VIS = 12, SV_FP = 2, SV_SYNC = 3, SV_BP = 3;
  localparam int S_HTOT = SH_VIS + SH_FP + SH_SYNC + SH_BP;
  localparam int S_VTOT = SV_VIS + SV_FP + SV_SYNC + SV_BP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [7:0] rgb = 8'h00;

  logic s_hs, s_vs, s_von;
  logic [9:0] s_h, s_v;
  logic [2:0] s_r, s_g;
  logic [1:0] s_b;

  logic f_hs, f_vs, f_von;
  logic [9:0] f_h, f_v;
  logic [2:0] f_r, f_g;
  logic [1:0] f_b;

  vga_scan_timer #(
    .H_VIS(SH_VIS), .H_FP(SH_FP), .H_SYNC(SH_SYNC), .H_BP(SH_BP),
    .V_VIS(SV_VIS), .V_FP(SV_FP), .V_SYNC(SV_SYNC), .V_BP(SV_BP),
    .HS_HIGH(1'b1), .VS_HIGH(1'b0), .CW(10)
  ) u_vga_scan_timer (
    .clk(clk), .rst_n(rst_n), .pix_en(en), .pix_rgb(rgb),
    .hsync(s_hs), .vsync(s_vs), .hpos(s_h), .vpos(s_v), .video_on(s_von),
    .red(s_r), .green(s_g), .blue(s_b)
  );

  vga_scan_timer u_vga_scan_timer_full (
    .clk(clk), .rst_n(rst_n), .pix_en(1'b1), .pix_rgb(rgb),
    .hsync(f_hs), .vsync(f_vs), .hpos(f_h), .vpos(f_v), .video_on(f_von),
    .red(f_r), .green(f_g), .blue(f_b)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int sh = 0, sv = 0, fh = 0, fv = 0;
  int checks = 0, errors = 0;
  int both_sync = 0;
  bit last_en = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      sh = 0; sv = 0; fh = 0; fv = 0;
    end else begin
      if (en) begin
        if (sh == S_HTOT - 1) begin
          sh = 0;
          sv = (sv == S_VTOT - 1) ? 0 : sv + 1;
        end else sh = sh + 1;
      end
      if (fh == 799) begin
        fh = 0;
        fv = (fv == 524) ? 0 : fv + 1;
      end else fh = fh + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit act_s, act_f;
    string hreq;
    hreq = last_en ? "R3" : "R2";
    chk(hreq, "small hpos", s_h, sh);
    chk("R4", "small vpos", s_v, sv);
    chk("R5", "small hsync", s_hs, (sh >= 23 && sh < 28) ? 1 : 0);
    chk("R6", "small vsync", s_vs, (sv >= 14 && sv < 17) ? 0 : 1);
    act_s = (sh < SH_VIS) && (sv < SV_VIS);
    chk("R7", "small video_on", s_von, act_s);
    chk("R8", "small rgb", {s_r, s_g, s_b}, act_s ? rgb : 0);
    chk("R3", "full hpos", f_h, fh);
    chk("R4", "full vpos", f_v, fv);
    chk("R5", "full hsync", f_hs, (fh >= 656 && fh < 752) ? 0 : 1);
    chk("R6", "full vsync", f_vs, (fv >= 490 && fv < 492) ? 0 : 1);
    act_f = (fh < 640) && (fv < 480);
    chk("R7", "full video_on", f_von, act_f);
    chk("R8", "full rgb", {f_r, f_g, f_b}, act_f ? rgb : 0);
    if (s_hs && !s_vs) both_sync++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset hpos", s_h, 0);
    chk("R1", "reset vpos", s_v, 0);
    chk("R1", "reset full hpos", f_h, 0);
    chk("R1", "reset video_on", s_von, 1);
    rst_n = 1'b1;
    for (int i = 0; i < 6000; i++) begin
      last_en = en;
      rgb = 8'($urandom);
      if (i < 2000) en = ($urandom % 4) != 0;
      else if (i < 2600) en = (i % 5) == 0;
      else en = 1'b1;
      rst_n = !(i == 4000 || i == 4001);
      @(negedge clk);
      compare();
      if (!rst_n) begin
        chk("R1", "hpos held in reset", s_h, 0);
        chk("R1", "vpos held in reset", s_v, 0);
      end
    end
    chk("R6", "hsync pulses during vsync", (both_sync > 0) ? 1 : 0, 1);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule